// File: doc/BRIEF.md
# Seconds Counter with Equality Alarm

This peripheral keeps a 32-bit count of elapsed seconds and signals an interrupt when that count reaches a programmed value. An external source supplies a one-cycle enable pulse once per second. Each pulse advances the count by one, and the count rolls over to zero after its largest value. Software reads and writes the block through a simple word-wide register port. It can set the count to any value, choose the alarm value, and stop or run the counting.

The alarm path has a sticky raw status bit, an enable mask, a masked status view and a write-one-to-clear register. The interrupt line is driven from the masked status. The raw bit latches on the cycle after the count first becomes equal to the alarm value. An equality that holds continuously does not set it again, so software can clear it while the count still sits on the alarm value.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset the count, alarm value, last-loaded value, mask and raw status are all zero, the run bit reads 1, and `irq_out` is low.
- R2: Reads of aligned byte addresses below 0x20 decode by word. 0x00 returns the count. 0x04 returns the alarm value. 0x08 returns the last value written to the load register. 0x0C returns the run bit in bit 0. 0x10 returns the mask. 0x14 returns the raw status. 0x18 returns the masked status. 0x1C returns 0. Unused bits, unaligned addresses and addresses of 0x20 and above read as 0. Writes to 0x00, 0x14 and 0x18 change nothing.
- R3: While the run bit is 1, each cycle with `tick_1hz` high adds one to the count. The count goes from 0xFFFFFFFF to 0.
- R4: A write to 0x08 sets the count to the written value on the next cycle. It takes priority over a tick in the same cycle.
- R5: Writing 0 to bit 0 of 0x0C clears the run bit. While the run bit is 0, ticks leave the count unchanged.
- R6: Raw status bit 0 becomes 1 one cycle after the count and alarm value first become equal, whatever the mask holds. An equality that already holds when reset is released does not set it.
- R7: Masked status bit 0 equals raw status bit 0 ANDed with mask bit 0.
- R8: Writing 0x1C with bit 0 set clears raw status bit 0. Writing it with bit 0 clear leaves the raw bit unchanged.
- R9: When an alarm event and a clearing write to 0x1C fall in the same cycle, the raw bit ends up 1.
- R10: `irq_out` is the OR of all masked status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle enable pulse, once per second |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the same cycle as a read |
| irq_out | output | 1 | Alarm interrupt request |

## Verification
A corrupted count shows up at the data register on the very next read. It shows up later as an alarm that arrives at the wrong tick or never arrives. A stuck or late edge detector is visible one cycle after the count lands on the alarm value, as a raw bit that fails to set, sets twice, or sets after reset. A wrong clear or mask path shows up at once on `irq_out` and in the masked status read. The bench checks `irq_out` every cycle, and it steers loads to just below the alarm value so that alarm events occur often.

// File: rtl/sa_pkg.sv
package sa_pkg;

  localparam int IRQ_W = 1;

  typedef enum logic [2:0] {
    IDX_COUNT = 3'd0,
    IDX_MATCH = 3'd1,
    IDX_LOAD  = 3'd2,
    IDX_CTRL  = 3'd3,
    IDX_MASK  = 3'd4,
    IDX_RAW   = 3'd5,
    IDX_MSTAT = 3'd6,
    IDX_CLEAR = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic match;
    logic load;
    logic ctrl;
    logic mask;
    logic clear;
  } wr_strobe_t;

  // Sticky status: a new event wins over a clear request.
  function automatic logic [IRQ_W-1:0] status_next(
    input logic [IRQ_W-1:0] cur,
    input logic [IRQ_W-1:0] set,
    input logic [IRQ_W-1:0] clr
  );
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/sa_decode.sv
module sa_decode
  import sa_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_strobe_t        we,
  output logic              rd_en,
  output reg_idx_e          rd_idx
);

  logic upper_zero;
  logic aligned;
  logic hit;
  logic wr_go;

  generate
    if (ADDR_W > 5) begin : g_hi
      assign upper_zero = (bus_addr[ADDR_W-1:5] == '0);
    end else begin : g_nohi
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign hit     = bus_sel & aligned & upper_zero;
  assign rd_idx  = reg_idx_e'(bus_addr[4:2]);
  assign rd_en   = hit & ~bus_wr;
  assign wr_go   = hit & bus_wr;

  always_comb begin
    we = '0;
    if (wr_go) begin
      case (rd_idx)
        IDX_MATCH: we.match = 1'b1;
        IDX_LOAD:  we.load  = 1'b1;
        IDX_CTRL:  we.ctrl  = 1'b1;
        IDX_MASK:  we.mask  = 1'b1;
        IDX_CLEAR: we.clear = 1'b1;
        default:   we = '0;
      endcase
    end
  end

endmodule

// File: rtl/sa_counter.sv
module sa_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  output logic             adv,
  output logic [CNT_W-1:0] cnt
);

  // Load beats advance; advance wraps naturally at the top.
  function automatic logic [CNT_W-1:0] count_step(
    input logic [CNT_W-1:0] cur,
    input logic             step,
    input logic             ld,
    input logic [CNT_W-1:0] ld_val
  );
    if (ld)        return ld_val;
    else if (step) return cur + CNT_W'(1);
    else           return cur;
  endfunction

  assign adv = tick & run;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= count_step(cnt, adv, load_we, load_val);
  end

endmodule

// File: rtl/sa_alarm.sv
module sa_alarm
  import sa_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] match_val,
  input  logic [IRQ_W-1:0] mask,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_bits,
  output logic             hit,
  output logic             evt,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mstat,
  output logic             irq
);

  logic             hit_q;
  logic [IRQ_W-1:0] set_vec;
  logic [IRQ_W-1:0] clr_vec;

  assign hit     = (cnt == match_val);
  assign evt     = hit & ~hit_q;
  assign set_vec = IRQ_W'(evt);
  assign clr_vec = clr_we ? clr_bits : '0;

  // hit_q starts high so equality present at reset raises no event.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b1;
      raw   <= '0;
    end else begin
      hit_q <= hit;
      raw   <= status_next(raw, set_vec, clr_vec);
    end
  end

  assign mstat = raw & mask;
  assign irq   = |mstat;

endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  localparam int PAD_W = DATA_W - IRQ_W;

  wr_strobe_t       we;
  logic             rd_en;
  reg_idx_e         rd_idx;

  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] load_q;
  logic              run_q;
  logic [IRQ_W-1:0]  mask_q;

  // Named internal events for the checker.
  logic              load_we;
  logic              clr_we;
  logic              adv;
  logic [DATA_W-1:0] cnt_q;
  logic              hit;
  logic              match_evt;
  logic [IRQ_W-1:0]  raw_q;
  logic [IRQ_W-1:0]  mstat;

  sa_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .we      (we),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx)
  );

  assign load_we = we.load;
  assign clr_we  = we.clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      load_q  <= '0;
      run_q   <= 1'b1;
      mask_q  <= '0;
    end else begin
      if (we.match) match_q <= bus_wdata;
      if (we.load)  load_q  <= bus_wdata;
      if (we.ctrl)  run_q   <= bus_wdata[0];
      if (we.mask)  mask_q  <= bus_wdata[IRQ_W-1:0];
    end
  end

  sa_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1hz),
    .run     (run_q),
    .load_we (load_we),
    .load_val(bus_wdata),
    .adv     (adv),
    .cnt     (cnt_q)
  );

  sa_alarm #(.CNT_W(DATA_W)) u_alm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt_q),
    .match_val(match_q),
    .mask     (mask_q),
    .clr_we   (clr_we),
    .clr_bits (bus_wdata[IRQ_W-1:0]),
    .hit      (hit),
    .evt      (match_evt),
    .raw      (raw_q),
    .mstat    (mstat),
    .irq      (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (rd_idx)
        IDX_COUNT: bus_rdata = cnt_q;
        IDX_MATCH: bus_rdata = match_q;
        IDX_LOAD:  bus_rdata = load_q;
        IDX_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, run_q};
        IDX_MASK:  bus_rdata = {{PAD_W{1'b0}}, mask_q};
        IDX_RAW:   bus_rdata = {{PAD_W{1'b0}}, raw_q};
        IDX_MSTAT: bus_rdata = {{PAD_W{1'b0}}, mstat};
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              load_we,
  input logic              run_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              hit,
  input logic              match_evt,
  input logic              clr_we,
  input logic              raw_bit,
  input logic              mask_bit,
  input logic              irq_out
);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> cnt_q == $past(bus_wdata));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && (!tick_1hz || !run_q)) |=> $stable(cnt_q));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && tick_1hz && run_q && (cnt_q == '1)) |=> cnt_q == '0);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && tick_1hz && run_q) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> raw_bit);

  assert_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && $past(hit)) |-> !match_evt);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && bus_wdata[0] && !match_evt) |=> !raw_bit);

  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !bus_wdata[0] && raw_bit) |=> raw_bit);

  assert_setwins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && bus_wdata[0] && match_evt) |=> raw_bit);

  assert_irqmask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_bit || !raw_bit) |-> !irq_out);

endmodule

bind sec_alarm_timer sa_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_1hz (tick_1hz),
  .bus_wdata(bus_wdata),
  .load_we  (load_we),
  .run_q    (run_q),
  .cnt_q    (cnt_q),
  .hit      (hit),
  .match_evt(match_evt),
  .clr_we   (clr_we),
  .raw_bit  (raw_q[0]),
  .mask_bit (mask_q[0]),
  .irq_out  (irq_out)
);

// File: tb/sec_alarm_timer_test.sv
`timescale 1ns/1ps
module sec_alarm_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sec_alarm_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // Reference state built from the requirements.
  logic [31:0] m_cnt, m_match, m_load;
  logic        m_run, m_mask, m_raw, m_hitq;

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a[1:0] != 2'b00 || a[5]) return 32'h0;
    case (a[4:2])
      3'd0: return m_cnt;
      3'd1: return m_match;
      3'd2: return m_load;
      3'd3: return {31'h0, m_run};
      3'd4: return {31'h0, m_mask};
      3'd5: return {31'h0, m_raw};
      3'd6: return {31'h0, m_raw & m_mask};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit is_wr(input logic [5:0] a);
    return bus_sel && bus_wr && bus_addr == a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_match = 0; m_load = 0; m_run = 1'b1;
      m_mask = 0; m_raw = 0; m_hitq = 1'b1;
    end else begin
      logic h, e, c;
      logic [31:0] nc;
      h = (m_cnt == m_match);
      e = h && !m_hitq;
      c = is_wr(6'h1C) && bus_wdata[0];
      nc = is_wr(6'h08) ? bus_wdata : ((tick_1hz && m_run) ? m_cnt + 1 : m_cnt);
      m_hitq = h;
      m_raw = e ? 1'b1 : (c ? 1'b0 : m_raw);
      if (is_wr(6'h04)) m_match = bus_wdata;
      if (is_wr(6'h08)) m_load = bus_wdata;
      if (is_wr(6'h0C)) m_run = bus_wdata[0];
      if (is_wr(6'h10)) m_mask = bus_wdata[0];
      m_cnt = nc;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one cycle, ends at the next negedge.
  task automatic cyc(input bit s, input bit w, input logic [5:0] a, input logic [31:0] d, input bit t);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; tick_1hz = t;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tick_1hz = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0);
  endtask

  task automatic rd_expect(input logic [5:0] a, input logic [31:0] exp, input string req);
    bus_sel = 1; bus_wr = 0; bus_addr = a; tick_1hz = 0;
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state; R6 equality present at reset raises nothing
    #1 chk(irq_out == 1'b0, "R1 irq after reset", {31'h0, irq_out}, 32'h0);
    rd_expect(6'h00, 32'h0, "R1 count");
    rd_expect(6'h04, 32'h0, "R1 match");
    rd_expect(6'h08, 32'h0, "R1 load");
    rd_expect(6'h0C, 32'h1, "R1 run bit");
    rd_expect(6'h10, 32'h0, "R1 mask");
    rd_expect(6'h14, 32'h0, "R6 raw not set by reset equality");
    rd_expect(6'h18, 32'h0, "R1 masked status");
    rd_expect(6'h1C, 32'h0, "R2 clear reads zero");

    // R2 writes to read-only offsets ignored, unaligned/out of range read zero
    wr(6'h00, 32'hDEAD0000);
    wr(6'h14, 32'hFFFFFFFF);
    wr(6'h18, 32'hFFFFFFFF);
    rd_expect(6'h00, 32'h0, "R2 data write ignored");
    rd_expect(6'h14, 32'h0, "R2 raw write ignored");
    wr(6'h04, 32'h0000ABCD);
    rd_expect(6'h06, 32'h0, "R2 unaligned reads zero");
    rd_expect(6'h24, 32'h0, "R2 high address reads zero");
    rd_expect(6'h04, 32'h0000ABCD, "R2 match readback");
    wr(6'h04, 32'h0);

    // R3 wrap
    wr(6'h08, 32'hFFFFFFFE);
    rd_expect(6'h08, 32'hFFFFFFFE, "R2 load readback");
    cyc(0, 0, 6'h0, 32'h0, 1'b1);
    cyc(0, 0, 6'h0, 32'h0, 1'b1);
    rd_expect(6'h00, 32'h0, "R3 wrap to zero");
    wr(6'h1C, 32'h1);
    rd_expect(6'h14, 32'h0, "R8 clear raw");

    // R4 load beats tick
    cyc(1, 1, 6'h08, 32'h00001234, 1'b1);
    rd_expect(6'h00, 32'h00001234, "R4 load priority over tick");

    // R5 stop
    wr(6'h0C, 32'h0);
    repeat (3) cyc(0, 0, 6'h0, 32'h0, 1'b1);
    rd_expect(6'h00, 32'h00001234, "R5 ticks ignored while stopped");
    rd_expect(6'h0C, 32'h0, "R5 run bit cleared");
    wr(6'h0C, 32'h1);
    cyc(0, 0, 6'h0, 32'h0, 1'b1);
    rd_expect(6'h00, 32'h00001235, "R3 increment");

    // R6 R7 R8 R10
    wr(6'h04, 32'd100);
    wr(6'h08, 32'd98);
    cyc(0, 0, 6'h0, 32'h0, 1'b1);
    cyc(0, 0, 6'h0, 32'h0, 1'b1);
    cyc(0, 0, 6'h0, 32'h0, 1'b0);
    rd_expect(6'h14, 32'h1, "R6 raw set with mask off");
    rd_expect(6'h18, 32'h0, "R7 masked status off");
    #1 chk(irq_out == 1'b0, "R10 irq masked", {31'h0, irq_out}, 32'h0);
    wr(6'h10, 32'h1);
    rd_expect(6'h18, 32'h1, "R7 masked status on");
    #1 chk(irq_out == 1'b1, "R10 irq asserted", {31'h0, irq_out}, 32'h1);
    wr(6'h1C, 32'hFFFFFFFE);
    rd_expect(6'h14, 32'h1, "R8 clear with bit0 zero ignored");
    wr(6'h1C, 32'h1);
    rd_expect(6'h14, 32'h0, "R8 clear with bit0 one");
    #1 chk(irq_out == 1'b0, "R10 irq drops", {31'h0, irq_out}, 32'h0);

    // R9 set wins
    wr(6'h04, 32'd200);
    wr(6'h08, 32'd199);
    cyc(0, 0, 6'h0, 32'h0, 1'b1);
    wr(6'h1C, 32'h1);
    rd_expect(6'h14, 32'h1, "R9 set wins over clear");
    #1 chk(irq_out == 1'b1, "R9 irq after set wins", {31'h0, irq_out}, 32'h1);
    wr(6'h1C, 32'h1);

    // Random phase against the reference state
    for (int i = 0; i < 6000; i++) begin
      int unsigned op;
      logic [5:0] a;
      logic [31:0] d;
      bit t;
      op = $urandom % 16;
      t = ($urandom % 2) == 1;
      d = $urandom;
      case (op)
        0, 1, 2, 3, 4: begin
          a = 6'(($urandom % 8) * 4);
          if ($urandom % 8 == 0) a = 6'($urandom);
          bus_sel = 1; bus_wr = 0; bus_addr = a; tick_1hz = t;
          #1;
          chk(bus_rdata == model_read(a), "R2 random read", bus_rdata, model_read(a));
          chk(irq_out == (m_raw & m_mask), "R10 random irq", {31'h0, irq_out}, {31'h0, m_raw & m_mask});
          @(negedge clk);
          bus_sel = 0; tick_1hz = 0;
        end
        5, 6: cyc(1, 1, 6'h08, m_match - ($urandom % 4), t);
        7: cyc(1, 1, 6'h04, (($urandom % 2) == 1) ? m_cnt + ($urandom % 4) : d, t);
        8: cyc(1, 1, 6'h10, d, t);
        9: cyc(1, 1, 6'h0C, {31'h0, ($urandom % 8) != 0}, t);
        10: cyc(1, 1, 6'h1C, d, t);
        11: cyc(1, 1, 6'(($urandom % 3 == 0) ? 6'h00 : (($urandom % 2 == 0) ? 6'h14 : 6'h18)), d, t);
        default: cyc(0, 0, 6'h0, 32'h0, t);
      endcase
    end

    #1 chk(irq_out == (m_raw & m_mask), "R10 final irq", {31'h0, irq_out}, {31'h0, m_raw & m_mask});
    finish_run();
  end

endmodule